// File: doc/BRIEF.md
# Peak-Tracking Symbol Timing Recovery

This block picks one sample per symbol out of an oversampled, signed stream of matched-filter outputs. The stream carries a fixed integer number of samples per symbol (`SPS`). Nothing is accepted until an upstream enable declares the carrier loop settled. After that the block opens an acquisition window of `ACQ_SYM` symbols. In that window every sampling position inside the symbol collects the sum of its sample magnitudes. The position with the largest sum becomes the sampling phase.

Once a phase is chosen, the block emits one decimated sample per symbol, together with a one-cycle strobe. It follows slow timing drift by comparing the magnitudes of the two neighbours around each chosen sample. The signed differences add up in an accumulator. When the accumulator passes a threshold, the sampling point moves by one sample, either later or earlier. The current phase is available on a debug output.

Top module: `symtime_recover`

## Requirements
- R1: While `warm_done` is low, every sample is ignored, `out_valid` stays low and `out_phase` reads 0. The first accepted sample after `warm_done` rises has index 0, and acquisition starts again from it.
- R2: An accepted sample is one with `in_valid` and `warm_done` both high. Cycles with `in_valid` low change nothing. Accepted sample n sits at position n mod `SPS`. The acquisition window covers the first `ACQ_SYM*SPS` accepted samples, and no strobe is produced during it.
- R3: The score of each position is the sum of the absolute values of its samples in the window, with negative samples counted by magnitude. The position with the highest score is chosen.
- R4: When scores tie, the lowest position wins.
- R5: At the end of the window `out_phase` shows the chosen position p. The first strobe follows accepted sample `ACQ_SYM*SPS+p+1` and carries sample `ACQ_SYM*SPS+p`.
- R6: A strobe is a single-cycle `out_valid` pulse, registered at the clock edge that accepts the triggering sample. `out_sample` holds the sample accepted just before the triggering one. Without a phase shift, strobes are exactly `SPS` accepted samples apart.
- R7: At every strobe the accumulator adds |late| − |early|. Here late is the triggering sample and early is the sample two before it. A sum above `THRESH` moves the phase one later, and the next strobe comes `SPS+1` samples later. A sum below −`THRESH` moves the phase one earlier, and the next strobe comes `SPS-1` samples later. A sum exactly equal to ±`THRESH` does not shift.
- R8: The accumulator is cleared after every phase shift.
- R9: The phase wraps: one step later from `SPS-1` gives 0, and one step earlier from 0 gives `SPS-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | DW | Signed two's-complement matched-filter sample |
| warm_done | input | 1 | High once warmup is over; low holds the block cleared |
| out_valid | output | 1 | One-cycle strobe per recovered symbol |
| out_sample | output | DW | Decimated on-time sample |
| out_phase | output | $clog2(SPS) | Current sampling position inside the symbol |

## Verification
The bench builds the block with DW=8, SPS=4, ACQ_SYM=4 and THRESH=30. With these values the acquisition window is only 16 samples long, so a whole scenario fits in a few dozen samples. Neighbour magnitudes of 10 and 40 give a step of exactly 30, so the accumulator lands on the threshold without crossing it, then crosses it on the next symbol. A chosen phase of 3 or 0 reaches both wrap directions within two strobes. The alternating symbol signs would cancel the scores to zero if magnitudes were summed without the absolute value.

// File: rtl/stl_pkg.sv
package stl_pkg;
  // Controller state: acquisition search or steady tracking.
  typedef enum logic {
    ST_ACQ   = 1'b0,
    ST_TRACK = 1'b1
  } stl_state_e;
endpackage

// File: rtl/stl_scorer.sv
// Per-position magnitude sums over the acquisition window and argmax.
module stl_scorer #(
  parameter int DW  = 12,
  parameter int SPS = 8,
  parameter int SW  = 17,
  parameter int PW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add,
  input  logic [PW-1:0] idx,
  input  logic [DW-1:0] mag,
  output logic [PW-1:0] best
);
  logic [SW-1:0] score [SPS];

  for (genvar g = 0; g < SPS; g++) begin : g_bin
    logic          hit;
    logic [SW-1:0] sum_q, sum_d;
    assign hit = add && (idx == PW'(g));
    // score includes the sample arriving this cycle, so the final
    // window sample takes part in the decision
    assign score[g] = sum_q + (hit ? SW'(mag) : SW'(0));

    always_comb begin
      sum_d = sum_q;
      if (clr)      sum_d = '0;
      else if (hit) sum_d = score[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sum_q <= '0;
      else        sum_q <= sum_d;
    end
  end

  // strict compare: the earliest position keeps a tie
  always_comb begin
    logic [SW-1:0] best_v;
    best   = '0;
    best_v = score[0];
    for (int i = 1; i < SPS; i++) begin
      if (score[i] > best_v) begin
        best_v = score[i];
        best   = PW'(i);
      end
    end
  end
endmodule

// File: rtl/stl_early_late.sv
// Early-late drift accumulator with symmetric threshold decision.
module stl_early_late #(
  parameter int DW     = 12,
  parameter int AW     = 23,
  parameter int THRESH = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  logic [DW-1:0] early_mag,
  input  logic [DW-1:0] late_mag,
  output logic          step_late,
  output logic          step_early
);
  localparam logic signed [AW-1:0] LIM = AW'(THRESH);

  logic signed [AW-1:0] acc_q, acc_d, acc_sum;

  assign acc_sum    = acc_q + $signed(AW'(late_mag)) - $signed(AW'(early_mag));
  assign step_late  = upd && (acc_sum > LIM);
  assign step_early = upd && (acc_sum < -LIM);

  always_comb begin
    acc_d = acc_q;
    if (clr)                          acc_d = '0;
    else if (step_late || step_early) acc_d = '0;
    else if (upd)                     acc_d = acc_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/symtime_recover.sv
// Symbol timing recovery: acquisition by magnitude score, tracking by
// thresholded early-late drift.
module symtime_recover
  import stl_pkg::*;
#(
  parameter int DW      = 12,
  parameter int SPS     = 8,
  parameter int ACQ_SYM = 16,
  parameter int THRESH  = 256
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  in_valid,
  input  logic [DW-1:0]                         in_sample,
  input  logic                                  warm_done,
  output logic                                  out_valid,
  output logic [DW-1:0]                         out_sample,
  output logic [((SPS > 1) ? $clog2(SPS) : 1)-1:0] out_phase
);
  localparam int PW = (SPS > 1) ? $clog2(SPS) : 1;
  localparam int YW = (ACQ_SYM > 1) ? $clog2(ACQ_SYM) : 1;
  localparam int SW = DW + YW + 1;
  localparam int CW = $clog2(SPS + 1);
  localparam int AW = DW + $clog2(THRESH + 1) + 2;
  localparam logic [PW-1:0] POS_LAST = PW'(SPS - 1);
  localparam logic [YW-1:0] SYM_LAST = YW'(ACQ_SYM - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  stl_state_e    st_q, st_d;
  logic [PW-1:0] pos_q, pos_d, ph_q, ph_d, best_ph;
  logic [YW-1:0] sym_q, sym_d;
  logic [CW-1:0] cd_q, cd_d;
  logic [DW-1:0] d0_q, d0_d, d1_q, d1_d, os_q, os_d;
  logic          ov_q, ov_d;
  logic [DW-1:0] mag_now, mag_d1;
  logic          take, trk, acq_add, acq_done, emit;
  logic          step_late, step_early;

  assign take     = in_valid && warm_done;
  assign trk      = (st_q == ST_TRACK);
  assign acq_add  = take && !trk;
  assign acq_done = acq_add && (pos_q == POS_LAST) && (sym_q == SYM_LAST);
  assign emit     = take && trk && (cd_q == '0);
  assign mag_now  = in_sample[DW-1] ? DW'(-in_sample) : in_sample;
  assign mag_d1   = d1_q[DW-1] ? DW'(-d1_q) : d1_q;

  stl_scorer #(.DW(DW), .SPS(SPS), .SW(SW), .PW(PW)) u_score (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr   (!warm_done),
    .add   (acq_add),
    .idx   (pos_q),
    .mag   (mag_now),
    .best  (best_ph)
  );

  stl_early_late #(.DW(DW), .AW(AW), .THRESH(THRESH)) u_el (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .clr        (!warm_done),
    .upd        (emit),
    .early_mag  (mag_d1),
    .late_mag   (mag_now),
    .step_late  (step_late),
    .step_early (step_early)
  );

  always_comb begin
    st_d  = st_q;
    pos_d = pos_q;
    sym_d = sym_q;
    cd_d  = cd_q;
    ph_d  = ph_q;
    d0_d  = d0_q;
    d1_d  = d1_q;
    os_d  = os_q;
    ov_d  = 1'b0;
    if (!warm_done) begin
      st_d  = ST_ACQ;
      pos_d = '0;
      sym_d = '0;
      cd_d  = '0;
      ph_d  = '0;
      d0_d  = '0;
      d1_d  = '0;
      os_d  = '0;
    end else if (take) begin
      d1_d = d0_q;
      d0_d = in_sample;
      if (!trk) begin
        pos_d = (pos_q == POS_LAST) ? '0 : pos_q + PW'(1);
        if (pos_q == POS_LAST) sym_d = sym_q + YW'(1);
        if (acq_done) begin
          st_d = ST_TRACK;
          ph_d = best_ph;
          cd_d = CW'(best_ph) + CW'(1);
        end
      end else if (emit) begin
        ov_d = 1'b1;
        os_d = d0_q;
        if (step_late) begin
          ph_d = (ph_q == POS_LAST) ? '0 : ph_q + PW'(1);
          cd_d = CW'(SPS);
        end else if (step_early) begin
          ph_d = (ph_q == '0) ? POS_LAST : ph_q - PW'(1);
          cd_d = CW'(SPS - 2);
        end else begin
          cd_d = CW'(SPS - 1);
        end
      end else begin
        cd_d = cd_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q  <= ST_ACQ;
      pos_q <= '0;
      sym_q <= '0;
      cd_q  <= '0;
      ph_q  <= '0;
      d0_q  <= '0;
      d1_q  <= '0;
      os_q  <= '0;
      ov_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      pos_q <= pos_d;
      sym_q <= sym_d;
      cd_q  <= cd_d;
      ph_q  <= ph_d;
      d0_q  <= d0_d;
      d1_q  <= d1_d;
      os_q  <= os_d;
      ov_q  <= ov_d;
    end
  end

  assign out_valid  = ov_q;
  assign out_sample = os_q;
  assign out_phase  = ph_q;
endmodule

// File: rtl/stl_checker.sv
module stl_checker #(
  parameter int SPS = 8,
  parameter int PW  = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          warm_done,
  input logic          in_valid,
  input logic          out_valid,
  input logic [PW-1:0] out_phase,
  input logic          trk
);
  localparam int GW = $clog2(SPS + 3) + 1;
  localparam logic [PW-1:0] PH_LAST = PW'(SPS - 1);

  logic [GW-1:0] gap_q;
  logic          seen_q, prev_trk_q;
  logic [PW-1:0] prev_ph_q, ph_up, ph_dn;

  assign ph_up = (prev_ph_q == PH_LAST) ? '0 : prev_ph_q + PW'(1);
  assign ph_dn = (prev_ph_q == '0) ? PH_LAST : prev_ph_q - PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q      <= '0;
      seen_q     <= 1'b0;
      prev_trk_q <= 1'b0;
      prev_ph_q  <= '0;
    end else begin
      prev_trk_q <= trk;
      prev_ph_q  <= out_phase;
      if (!warm_done) begin
        gap_q  <= '0;
        seen_q <= 1'b0;
      end else begin
        if (out_valid) begin
          seen_q <= 1'b1;
          gap_q  <= in_valid ? GW'(1) : GW'(0);
        end else if (in_valid && gap_q < GW'(SPS + 2)) begin
          gap_q <= gap_q + GW'(1);
        end
      end
    end
  end

  AST_COLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !warm_done |=> !out_valid);                                       // R1
  AST_NO_STROBE_IN_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> trk);                                               // R2
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);                                        // R6
  AST_SYMBOL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen_q && warm_done) |->
      (gap_q >= GW'(SPS - 1) && gap_q <= GW'(SPS + 1)));              // R7
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (trk && prev_trk_q) |->
      (out_phase == prev_ph_q || out_phase == ph_up || out_phase == ph_dn)); // R9
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_phase <= PH_LAST);                                            // R9
endmodule

bind symtime_recover stl_checker #(.SPS(SPS), .PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .warm_done (warm_done),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_phase (out_phase),
  .trk       (trk)
);

// File: tb/tb_symtime_recover.sv
module tb_symtime_recover;
  localparam int DW = 8;
  localparam int SPS = 4;
  localparam int ACQ = 4;
  localparam int TH = 30;
  localparam int PW = 2;
  localparam int WIN = ACQ * SPS;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] in_sample;
  logic          warm_done;
  logic          out_valid;
  logic [DW-1:0] out_sample;
  logic [PW-1:0] out_phase;

  int n_chk = 0;
  int n_bad = 0;
  logic          g_v;
  logic [DW-1:0] g_s;
  logic [PW-1:0] g_p;

  always #10 clk = ~clk;

  symtime_recover #(.DW(DW), .SPS(SPS), .ACQ_SYM(ACQ), .THRESH(TH)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .warm_done  (warm_done),
    .out_valid  (out_valid),
    .out_sample (out_sample),
    .out_phase  (out_phase)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // value of sample idx: position magnitude, sign alternating per symbol
  function automatic int smp(input int idx, input int ma[4], input int mt[4]);
    int m;
    m = (idx < WIN) ? ma[idx % SPS] : mt[idx % SPS];
    return (((idx / SPS) % 2) == 1) ? -m : m;
  endfunction

  // one accepted sample, then an idle cycle carrying junk data
  task automatic send(input int v);
    in_valid  = 1'b1;
    in_sample = DW'(v);
    @(negedge clk);
    g_v = out_valid;
    g_s = out_sample;
    g_p = out_phase;
    in_valid  = 1'b0;
    in_sample = 8'h7F;
    @(negedge clk);
  endtask

  task automatic restart();
    warm_done = 1'b0;
    @(negedge clk);
    @(negedge clk);
    warm_done = 1'b1;
  endtask

  task automatic run(input string tag, input int ma[4], input int mt[4], input int nsamp,
                     input int em[6], input int ph[6], input int ne);
    int k;
    k = 0;
    for (int idx = 0; idx < nsamp; idx++) begin
      bit expv;
      send(smp(idx, ma, mt));
      expv = (k < ne) && (em[k] == idx);
      check_eq($sformatf("%s strobe at sample %0d", tag, idx), int'(g_v), int'(expv));
      if (expv) begin
        check_eq($sformatf("%s value at sample %0d", tag, idx),
                 int'($signed(g_s)), smp(idx - 1, ma, mt));
        check_eq($sformatf("%s phase at sample %0d", tag, idx), int'(g_p), ph[k]);
        k++;
      end
    end
  endtask

  task automatic t_reset();
    check_eq("R1 reset out_valid", int'(out_valid), 0);
    check_eq("R1 reset out_phase", int'(out_phase), 0);
  endtask

  // R1: samples while cold are ignored; then R2 window, R5 first strobe, R6 spacing
  task automatic t_warm_then_lock();
    warm_done = 1'b0;
    for (int i = 0; i < 6; i++) begin
      send((i % SPS == 1) ? 120 : 5);
      check_eq("R1 cold strobe", int'(g_v), 0);
    end
    warm_done = 1'b1;
    run("R2 R5 R6", '{10, 10, 100, 10}, '{10, 10, 100, 10}, 28,
        '{19, 23, 27, 0, 0, 0}, '{2, 2, 2, 0, 0, 0}, 3);
  endtask

  // R3: alternating signs, magnitude decides
  task automatic t_abs_score();
    restart();
    run("R3", '{50, 90, 50, 50}, '{50, 90, 50, 50}, 24,
        '{18, 22, 0, 0, 0, 0}, '{1, 1, 0, 0, 0, 0}, 2);
  endtask

  // R4: equal scores pick position 0
  task automatic t_tie();
    restart();
    run("R4", '{30, 30, 30, 30}, '{30, 30, 30, 30}, 26,
        '{17, 21, 25, 0, 0, 0}, '{0, 0, 0, 0, 0, 0}, 3);
  endtask

  // R7 R8: equal-to-threshold holds, late shift, immediate early shift after clear
  task automatic t_drift();
    restart();
    run("R7 R8", '{10, 10, 100, 10}, '{10, 10, 100, 40}, 36,
        '{19, 23, 28, 31, 35, 0}, '{2, 3, 2, 2, 3, 0}, 5);
  endtask

  // R9: wrap 3->0 then 0->3
  task automatic t_wrap();
    restart();
    run("R9", '{10, 10, 10, 100}, '{40, 10, 10, 100}, 37,
        '{20, 24, 29, 32, 36, 0}, '{3, 0, 3, 3, 0, 0}, 5);
  endtask

  // R1: dropping warm_done mid-track clears the phase and silences output
  task automatic t_cold_drop();
    warm_done = 1'b0;
    for (int i = 0; i < 5; i++) begin
      send(100);
      check_eq("R1 drop strobe", int'(g_v), 0);
    end
    check_eq("R1 drop phase", int'(out_phase), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_sample = '0;
    warm_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_warm_then_lock();
    t_abs_score();
    t_tie();
    t_drift();
    t_cold_drop();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule